// File: doc/BRIEF.md
# Serial CAN CRC-15 Engine

This block computes the 15-bit cyclic redundancy sequence of a CAN frame one bit per accepted strobe. The bit stream it sees is the destuffed bit stream: the framing logic presents the Start-Of-Frame bit and every later bit up to the last data bit, and raises `bit_valid` only for real information bits. It never raises `bit_valid` for stuff bits. A one-cycle `frame_start` pulse clears the divider before the first bit of each frame.

The generator is x^15+x^14+x^10+x^8+x^7+x^4+x^3+1. This is a degree-14 BCH polynomial multiplied by (x+1), and the (x+1) factor adds a parity check. With `check_mode` low, a transmitter reads `crc_out` after the last data bit and sends it most significant bit first. With `check_mode` high, a receiver also clocks in the 15 received CRC bits and then pulses `crc_end`. The block then reports a mismatch on `crc_error` when the remainder is not zero.

Top module: `can_crc15_serial`

## Requirements
- R1: After reset, `crc_out` is 0 and `crc_error` is 0.
- R2: Each cycle with `bit_valid` high and `frame_start` low accepts `bit_in`. With f = bit_in XOR crc[14], the register becomes (crc shifted left by one, bit 0 filled with 0), XORed with 15'h4599 when f is 1. The first bit accepted is the highest-order coefficient, so `crc_out` equals the remainder of (message · x^15) divided by the generator.
- R3: `frame_start` clears the register to 0 on the next edge. It has priority over `bit_valid` in the same cycle, and the bit presented in that cycle is discarded.
- R4: A cycle with `bit_valid` low and `frame_start` low leaves `crc_out` unchanged, so gaps left for stuff bits do not alter the result.
- R5: In check mode, a frame followed by its own correct 15 CRC bits (MSB first), then a `crc_end` pulse, gives `crc_error` = 0 one cycle after the pulse.
- R6: In check mode, any single flipped bit, any odd number of flipped bits, and any burst of flipped bits no longer than 15 positions (over the frame plus its CRC bits) gives `crc_error` = 1 one cycle after `crc_end`.
- R7: In generate mode (`check_mode` = 0), a `crc_end` pulse leaves `crc_error` at 0.
- R8: `crc_error` changes only on the edge that follows a `crc_end` or a `frame_start` pulse. `frame_start` clears it to 0, and `frame_start` wins over `crc_end` when both are high in the same cycle.
- R9: The parity of `crc_out` (XOR of its 15 bits) equals the parity of the bits accepted since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_start | input | 1 | One-cycle pulse that clears the divider and the error flag |
| bit_valid | input | 1 | Strobe: `bit_in` is a destuffed bit to be absorbed |
| bit_in | input | 1 | Serial data bit |
| check_mode | input | 1 | 0 = generate, 1 = check received CRC |
| crc_end | input | 1 | Pulse after the last received CRC bit; samples the zero test |
| crc_out | output | 15 | Current remainder |
| crc_error | output | 1 | Registered mismatch flag for check mode |

## Verification
A corrupted bit of the remainder register shows on `crc_out` on the edge after the bit that corrupted it. Because the divider mixes every later bit into the register, the corruption does not die out: it remains in the final remainder, and in check mode it becomes a wrong `crc_error` one cycle after `crc_end`. Random frames of 1 to 83 bits, with idle gaps, are compared against a bench model of the division. Separate corrupted frames check that single, odd-count and short burst errors each raise the flag. A parity watch on `crc_out` catches any update that loses the (x+1) factor within the same cycle.

// File: rtl/can_crc15_pkg.sv
package can_crc15_pkg;
    localparam int          CRC_W    = 15;
    localparam logic [14:0] CRC_POLY = 15'h4599;

    typedef logic [CRC_W-1:0] crc_t;

    typedef struct packed {
        crc_t rem;
        logic par;
    } div_state_t;
endpackage

// File: rtl/can_crc15_step.sv
module can_crc15_step #(
    parameter int              W    = 15,
    parameter logic [W-1:0]    POLY = 15'h4599
) (
    input  logic [W-1:0] rem_in,
    input  logic         din,
    output logic [W-1:0] rem_out
);
    logic          fb;
    logic [W-1:0]  shifted;

    always_comb begin
        fb      = din ^ rem_in[W-1];
        shifted = {rem_in[W-2:0], 1'b0};
        rem_out = fb ? (shifted ^ POLY) : shifted;
    end
endmodule

// File: rtl/can_crc15_flag.sv
module can_crc15_flag #(
    parameter int W = 15
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         strobe,
    input  logic         check_mode,
    input  logic [W-1:0] rem_next,
    output logic         error
);
    typedef struct packed {
        logic err;
    } flag_state_t;

    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear) begin
            st_d.err = 1'b0;
        end else if (strobe) begin
            st_d.err = check_mode && (rem_next != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign error = st_q.err;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !strobe) |=> $stable(error)); // R8
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !error); // R8
    AST_GEN_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !check_mode) |=> !error); // R7
endmodule

// File: rtl/can_crc15_serial.sv
module can_crc15_serial
    import can_crc15_pkg::*;
#(
    parameter int          W    = CRC_W,
    parameter logic [W-1:0] POLY = CRC_POLY
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_start,
    input  logic         bit_valid,
    input  logic         bit_in,
    input  logic         check_mode,
    input  logic         crc_end,
    output logic [W-1:0] crc_out,
    output logic         crc_error
);
    logic [W-1:0] rem_q, rem_d, rem_step;
    logic         par_q, par_d;

    can_crc15_step #(.W(W), .POLY(POLY)) u_step (
        .rem_in  (rem_q),
        .din     (bit_in),
        .rem_out (rem_step)
    );

    always_comb begin
        rem_d = rem_q;
        par_d = par_q;
        if (frame_start) begin
            rem_d = '0;
            par_d = 1'b0;
        end else if (bit_valid) begin
            rem_d = rem_step;
            par_d = par_q ^ bit_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            par_q <= 1'b0;
        end else begin
            rem_q <= rem_d;
            par_q <= par_d;
        end
    end

    can_crc15_flag #(.W(W)) u_flag (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (frame_start),
        .strobe     (crc_end),
        .check_mode (check_mode),
        .rem_next   (rem_d),
        .error      (crc_error)
    );

    assign crc_out = rem_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (crc_out == '0)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && !bit_valid) |=> $stable(crc_out)); // R4
    AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (^crc_out) == par_q); // R9
endmodule

// File: tb/can_crc15_serial_bench.sv
`timescale 1ns/100ps
module can_crc15_serial_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        bit_valid = 1'b0;
    logic        bit_in = 1'b0;
    logic        check_mode = 1'b0;
    logic        crc_end = 1'b0;
    logic [14:0] crc_out;
    logic        crc_error;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    can_crc15_serial u_can_crc15_serial (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .bit_valid(bit_valid), .bit_in(bit_in), .check_mode(check_mode),
        .crc_end(crc_end), .crc_out(crc_out), .crc_error(crc_error)
    );

    function automatic logic [14:0] ref_crc(input logic [127:0] m, input int n);
        logic [14:0] c = '0;
        logic        f;
        for (int i = 0; i < n; i++) begin
            f = m[i] ^ c[14];
            c = {c[13:0], 1'b0};
            if (f) c = c ^ 15'h4599;
        end
        return c;
    endfunction

    function automatic logic ref_par(input logic [127:0] m, input int n);
        logic p = 1'b0;
        for (int i = 0; i < n; i++) p = p ^ m[i];
        return p;
    endfunction

    task automatic chk(input string req, input logic [14:0] act, input logic [14:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input logic fs, input logic v, input logic b, input logic e);
        @(negedge clk);
        frame_start = fs; bit_valid = v; bit_in = b; crc_end = e;
        @(negedge clk);
        frame_start = 0; bit_valid = 0; bit_in = 0; crc_end = 0;
    endtask

    task automatic feed(input logic [127:0] m, input int n, input bit gaps);
        tick(1, 0, 0, 0);
        for (int i = 0; i < n; i++) begin
            if (gaps && ($urandom % 4 == 0)) tick(0, 0, 1, 0);
            tick(0, 1, m[i], 0);
        end
    endtask

    function automatic logic [127:0] rand_frame(input int n);
        logic [127:0] m = '0;
        for (int i = 1; i < n; i++) m[i] = 1'($urandom);
        return m;
    endfunction

    function automatic logic [127:0] with_crc(input logic [127:0] m, input int n);
        logic [14:0] c = ref_crc(m, n);
        logic [127:0] r = m;
        for (int j = 0; j < 15; j++) r[n+j] = c[14-j];
        return r;
    endfunction

    initial begin
        logic [127:0] m, t;
        logic [14:0]  hold;
        int n, tot, s, len;
        void'($urandom(32'd4242));
        check_mode = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 crc_out", crc_out, 15'h0);
        chk("R1 crc_error", {14'h0, crc_error}, 15'h0);
        rst_n = 1'b1;

        // R2, R9: random generate-mode frames, also with idle gaps (R4)
        for (int k = 0; k < 40; k++) begin
            n = 1 + ($urandom % 83);
            m = rand_frame(n);
            feed(m, n, k[0]);
            chk(k[0] ? "R4 gaps remainder" : "R2 remainder", crc_out, ref_crc(m, n));
            chk("R9 parity", {14'h0, ^crc_out}, {14'h0, ref_par(m, n)});
        end
        // R2 directed: all-ones 83-bit frame after SOF, and lone SOF
        m = '0; for (int i = 1; i < 83; i++) m[i] = 1'b1;
        feed(m, 83, 0);
        chk("R2 ones frame", crc_out, ref_crc(m, 83));
        feed('0, 1, 0);
        chk("R2 sof only", crc_out, 15'h0);

        // R4: explicit idle cycle holds value
        m = rand_frame(20); feed(m, 20, 0);
        hold = crc_out;
        tick(0, 0, 1, 0); tick(0, 0, 0, 0);
        chk("R4 idle hold", crc_out, hold);

        // R3: clear wins over bit_valid, bit dropped
        tick(0, 1, 1, 0);
        tick(1, 1, 1, 0);
        chk("R3 clear with valid", crc_out, 15'h0);
        m = rand_frame(30);
        for (int i = 0; i < 30; i++) tick(0, 1, m[i], 0);
        chk("R3 after clear", crc_out, ref_crc(m, 30));

        // R7: generate-mode crc_end leaves flag low
        tick(0, 0, 0, 1);
        chk("R7 gen end", {14'h0, crc_error}, 15'h0);

        // R5: correct frames in check mode
        check_mode = 1'b1;
        for (int k = 0; k < 20; k++) begin
            n = 1 + ($urandom % 83);
            t = with_crc(rand_frame(n), n);
            feed(t, n + 15, k[0]);
            tick(0, 0, 0, 1);
            chk("R5 good frame", {14'h0, crc_error}, 15'h0);
        end

        // R6: single errors
        for (int k = 0; k < 20; k++) begin
            n = 1 + ($urandom % 83); tot = n + 15;
            t = with_crc(rand_frame(n), n);
            s = $urandom % tot; t[s] = ~t[s];
            feed(t, tot, 0); tick(0, 0, 0, 1);
            chk("R6 single error", {14'h0, crc_error}, 15'h1);
        end
        // R6: three distinct errors (odd count)
        for (int k = 0; k < 20; k++) begin
            n = 3 + ($urandom % 81); tot = n + 15;
            t = with_crc(rand_frame(n), n);
            len = tot / 3;
            s = $urandom % len;             t[s] = ~t[s];
            s = len + ($urandom % len);     t[s] = ~t[s];
            s = 2*len + ($urandom % len);   t[s] = ~t[s];
            feed(t, tot, 0); tick(0, 0, 0, 1);
            chk("R6 odd errors", {14'h0, crc_error}, 15'h1);
        end
        // R6: bursts of 2..15 positions
        for (int k = 0; k < 28; k++) begin
            n = 1 + ($urandom % 83); tot = n + 15;
            t = with_crc(rand_frame(n), n);
            len = 2 + (k % 14);
            s = $urandom % (tot - len + 1);
            t[s] = ~t[s]; t[s+len-1] = ~t[s+len-1];
            for (int i = 1; i < len - 1; i++) if ($urandom % 2 == 1) t[s+i] = ~t[s+i];
            feed(t, tot, 0); tick(0, 0, 0, 1);
            chk("R6 burst error", {14'h0, crc_error}, 15'h1);
            if (k == 0) begin
                // R8: flag held without strobe, then cleared by frame_start
                tick(0, 1, 1, 0); tick(0, 0, 0, 0);
                chk("R8 flag held", {14'h0, crc_error}, 15'h1);
                tick(1, 0, 0, 1);
                chk("R8 clear beats end", {14'h0, crc_error}, 15'h0);
            end
        end
        // R6: burst at the very end of the CRC bits, full 15 length
        n = 83; tot = 98;
        t = with_crc(rand_frame(n), n);
        t[tot-15] = ~t[tot-15]; t[tot-1] = ~t[tot-1];
        feed(t, tot, 0); tick(0, 0, 0, 1);
        chk("R6 tail burst 15", {14'h0, crc_error}, 15'h1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule